// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD bytes: seconds, minutes, hour, day of month, month, two-digit year and a weekday index. An internal sub-second counter divides the block clock down to one tick per second. Each tick moves the seconds forward, and carries ripple through minutes, hours, date, month and year, with the weekday index stepping in step with the date. The hour byte holds its own format select, so software can choose between a 0-23 count and a 1-12 count with a PM flag.

A host loads any single field through a one-cycle write port. A load also restarts the sub-second counter, so the next tick comes a full second after the load. A combinational read port returns any field at any time and never holds the count back. A one-cycle pulse follows each seconds increment so that alarm comparison logic outside the block knows when to sample.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, reads return seconds 00, minutes 00, hour 0x12 (12-hour format, PM clear, so 12 AM), date 0x01, month 0x01, year 0x00 and weekday 0.
- R2: Seconds and minutes count 00 to 59 in BCD. Seconds wrap from 59 to 00 and advance minutes. Minutes wrap from 59 to 00 and advance the hour.
- R3: With hour byte bit 7 set (24-hour format), bits 5:0 hold the hour 00 to 23 in BCD and bit 6 reads 0. The hour wraps from 23 to 00 and advances the date.
- R4: With hour byte bit 7 clear (12-hour format), bits 4:0 hold the hour 1 to 12 in BCD and bit 5 is the PM flag. 11 goes to 12 and flips PM. 12 goes to 1 with PM unchanged. The date advances only on the 11 PM to 12 AM step.
- R5: The date wraps to 01 and advances the month after day 31 in months 01, 03, 05, 07, 08, 10 and 12, after day 30 in months 04, 06, 09 and 11, and after day 28 in February of a non-leap year.
- R6: February has 29 days when the two-digit year is divisible by 4, and year 00 counts as a leap year.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R8: The weekday index counts 0 to 6, advances whenever the date advances and wraps from 6 to 0.
- R9: Field select codes are 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 weekday (bits 2:0). The same codes serve reads and writes. A write shows on rd_data after the next clock edge. rd_data follows rd_sel with no clock delay, and code 7 reads 0.
- R10: A write restarts the sub-second phase, and the first increment after it happens CYCLES_PER_SEC clock edges after the write edge. A tick that falls in the same cycle as a write is dropped.
- R11: With no writes, the seconds advance exactly once every CYCLES_PER_SEC clock cycles.
- R12: sec_pulse is high for exactly one cycle, the cycle right after each timed seconds increment, and is low at all other times, including after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; CYCLES_PER_SEC cycles make one second |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load wr_data into the field chosen by wr_sel |
| wr_sel | input | 3 | Field select for writes |
| wr_data | input | 8 | BCD value to load |
| rd_sel | input | 3 | Field select for reads |
| rd_data | output | 8 | Current value of the selected field |
| sec_pulse | output | 1 | One-cycle marker after each seconds increment |

## Verification
The bound checker watches the tick spacing against its own cycle counter on every cycle. It also checks that no tick coincides with a write, that the seconds and minutes wrap, that the 24-hour and 12 PM-to-1 hour steps behave, that the weekday and day-31 wraps happen, and that sec_pulse follows each timed seconds change. Month lengths by month, the leap rule across years, the 11 PM date carry, and how a write restarts the phase can only be seen in the bench's directed and random scenarios. There, a reference calendar in binary is compared against every field read back through the read port.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int HOUR_W = 6;
  localparam int DOW_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    F_SEC   = 3'd0,
    F_MIN   = 3'd1,
    F_HOUR  = 3'd2,
    F_DATE  = 3'd3,
    F_MONTH = 3'd4,
    F_YEAR  = 3'd5,
    F_DOW   = 3'd6
  } field_e;

  // one BCD step, 0x09 -> 0x10, 0x19 -> 0x20
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic logic year_is_leap(input logic [BYTE_W-1:0] yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [BYTE_W-1:0] month_len(input logic [BYTE_W-1:0] mo,
                                                  input logic [BYTE_W-1:0] yr);
    case (mo)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // next hour value; mode24=1 : 00..23, mode24=0 : 1..12
  function automatic logic [HOUR_W-1:0] next_hour(input logic mode24,
                                                  input logic [HOUR_W-1:0] h);
    logic [BYTE_W-1:0] t;
    t = bcd_inc({2'b00, h});
    if (mode24) return (h == 6'h23) ? 6'h00 : t[HOUR_W-1:0];
    else        return (h == 6'h12) ? 6'h01 : t[HOUR_W-1:0];
  endfunction
endpackage

// File: rtl/rtc_phase.sv
module rtc_phase #(
  parameter int CYC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign tick    = at_last && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart || at_last) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_clock_chain.sv
module rtc_clock_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] sec_q,
  output logic [BYTE_W-1:0] min_q,
  output logic              hour_mode,
  output logic              hour_pm,
  output logic [HOUR_W-1:0] hour_val,
  output logic              day_carry
);
  logic min_carry, hour_carry, pm_flip;

  assign min_carry  = tick && (sec_q == 8'h59);
  assign hour_carry = min_carry && (min_q == 8'h59);
  assign pm_flip    = !hour_mode && (hour_val == 6'h11);
  assign day_carry  = hour_carry &&
                      (hour_mode ? (hour_val == 6'h23) : (pm_flip && hour_pm));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q     <= 8'h00;
      min_q     <= 8'h00;
      hour_mode <= 1'b0;
      hour_pm   <= 1'b0;
      hour_val  <= 6'h12;
    end else if (wr_en) begin
      case (field_e'(wr_sel))
        F_SEC: sec_q <= wr_data;
        F_MIN: min_q <= wr_data;
        F_HOUR: begin
          hour_mode <= wr_data[7];
          if (wr_data[7]) begin
            hour_val <= wr_data[5:0];
            hour_pm  <= 1'b0;
          end else begin
            hour_val <= {1'b0, wr_data[4:0]};
            hour_pm  <= wr_data[5];
          end
        end
        default: ;
      endcase
    end else if (tick) begin
      sec_q <= min_carry ? 8'h00 : bcd_inc(sec_q);
      if (min_carry) min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (hour_carry) begin
        hour_val <= next_hour(hour_mode, hour_val);
        if (pm_flip) hour_pm <= !hour_pm;
      end
    end
  end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] date_q,
  output logic [BYTE_W-1:0] month_q,
  output logic [BYTE_W-1:0] year_q,
  output logic [DOW_W-1:0]  dow_q
);
  localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(6);

  logic month_end, year_end;

  assign month_end = day_carry && (date_q >= month_len(month_q, year_q));
  assign year_end  = month_end && (month_q >= 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
      dow_q   <= '0;
    end else if (wr_en) begin
      case (field_e'(wr_sel))
        F_DATE:  date_q  <= wr_data;
        F_MONTH: month_q <= wr_data;
        F_YEAR:  year_q  <= wr_data;
        F_DOW:   dow_q   <= wr_data[DOW_W-1:0];
        default: ;
      endcase
    end else if (day_carry) begin
      dow_q  <= (dow_q == DOW_LAST) ? '0 : dow_q + 1'b1;
      date_q <= month_end ? 8'h01 : bcd_inc(date_q);
      if (month_end) month_q <= year_end ? 8'h01 : bcd_inc(month_q);
      if (year_end)  year_q  <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int CYCLES_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  rd_sel,
  output logic [7:0]  rd_data,
  output logic        sec_pulse
);
  logic              tick;
  logic              day_carry;
  logic [BYTE_W-1:0] sec_q, min_q, date_q, month_q, year_q;
  logic              hour_mode, hour_pm;
  logic [HOUR_W-1:0] hour_val;
  logic [DOW_W-1:0]  dow_q;
  logic [BYTE_W-1:0] hour_rd;

  rtc_phase #(.CYC(CYCLES_PER_SEC)) u_phase (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .tick(tick)
  );

  rtc_clock_chain u_clock (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_q(sec_q), .min_q(min_q),
    .hour_mode(hour_mode), .hour_pm(hour_pm), .hour_val(hour_val),
    .day_carry(day_carry)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .date_q(date_q), .month_q(month_q), .year_q(year_q), .dow_q(dow_q)
  );

  assign hour_rd = hour_mode ? {2'b10, hour_val}
                             : {2'b00, hour_pm, hour_val[4:0]};

  always_comb begin
    case (field_e'(rd_sel))
      F_SEC:   rd_data = sec_q;
      F_MIN:   rd_data = min_q;
      F_HOUR:  rd_data = hour_rd;
      F_DATE:  rd_data = date_q;
      F_MONTH: rd_data = month_q;
      F_YEAR:  rd_data = year_q;
      F_DOW:   rd_data = {{(BYTE_W-DOW_W){1'b0}}, dow_q};
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_pulse <= 1'b0;
    else        sec_pulse <= tick;
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int CYC = 32768
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       tick,
  input logic       day_carry,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic       hour_mode,
  input logic       hour_pm,
  input logic [5:0] hour_val,
  input logic [7:0] date_q,
  input logic [2:0] dow_q,
  input logic       sec_pulse
);
  localparam int GW = $clog2(CYC) + 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(CYC - 1);

  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap <= '0;
    else if (wr_en || tick)   gap <= '0;
    else                      gap <= gap + 1'b1;
  end

  assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap == GAP_LAST));

  assert_no_tick_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !tick);

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec_q == 8'h59) |=> (sec_q == 8'h00));

  assert_min_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((min_q != $past(min_q)) && !$past(wr_en)) |-> ($past(tick) && $past(sec_q) == 8'h59));

  assert_hour24_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && hour_mode) |=> (hour_val == 6'h00));

  assert_noon_to_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hour_mode && hour_val == 6'h12 && min_q == 8'h59 && sec_q == 8'h59)
      |=> (hour_val == 6'h01 && $stable(hour_pm)));

  assert_day31_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && date_q == 8'h31) |=> (date_q == 8'h01));

  assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && dow_q == 3'd6) |=> (dow_q == 3'd0));

  assert_pulse_after_inc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((sec_q != $past(sec_q)) && !$past(wr_en)) |-> sec_pulse);

  assert_no_pulse_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> !sec_pulse);
endmodule

bind bcd_calendar rtc_calendar_chk #(.CYC(CYCLES_PER_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .day_carry(day_carry),
  .sec_q(sec_q), .min_q(min_q), .hour_mode(hour_mode), .hour_pm(hour_pm),
  .hour_val(hour_val), .date_q(date_q), .dow_q(dow_q), .sec_pulse(sec_pulse)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
  localparam int CYC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       sec_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  // reference model in plain binary
  int m_sec = 0, m_min = 0, m_h24 = 0, m_date = 1, m_mon = 1, m_year = 0, m_dow = 0;
  bit m_mode = 1'b0;
  int ph = 0;
  bit pulse_exp = 1'b0;

  bcd_calendar #(.CYCLES_PER_SEC(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sec_pulse(sec_pulse)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_of(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_field(int f);
    int hr12;
    case (f)
      0: return to_bcd(m_sec);
      1: return to_bcd(m_min);
      2: begin
        if (m_mode) return 8'h80 | to_bcd(m_h24);
        hr12 = (m_h24 % 12 == 0) ? 12 : m_h24 % 12;
        return ((m_h24 >= 12) ? 8'h20 : 8'h00) | to_bcd(hr12);
      end
      3: return to_bcd(m_date);
      4: return to_bcd(m_mon);
      5: return to_bcd(m_year);
      6: return 8'(m_dow);
      default: return 8'h00;
    endcase
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog expired: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic advance_day();
    m_dow = (m_dow + 1) % 7;
    if (m_date >= days_of(m_mon, m_year)) begin
      m_date = 1;
      if (m_mon >= 12) begin
        m_mon = 1;
        m_year = (m_year + 1) % 100;
      end else m_mon++;
    end else m_date++;
  endtask

  task automatic advance_sec();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_h24++;
        if (m_h24 == 24) begin
          m_h24 = 0;
          advance_day();
        end
      end
    end
  endtask

  task automatic apply_write(logic [2:0] sel, logic [7:0] d);
    case (sel)
      3'd0: m_sec = from_bcd(d);
      3'd1: m_min = from_bcd(d);
      3'd2: begin
        m_mode = d[7];
        if (d[7]) m_h24 = from_bcd(d & 8'h3F);
        else      m_h24 = (from_bcd(d & 8'h1F) % 12) + (d[5] ? 12 : 0);
      end
      3'd3: m_date = from_bcd(d);
      3'd4: m_mon = from_bcd(d);
      3'd5: m_year = from_bcd(d);
      3'd6: m_dow = int'(d[2:0]);
      default: ;
    endcase
  endtask

  // one clock: model update at the edge, pulse check at the falling edge
  task automatic step();
    @(posedge clk);
    if (wr_en) begin
      apply_write(wr_sel, wr_data); ph = 0; pulse_exp = 1'b0;
    end else if (ph == CYC - 1) begin
      advance_sec(); ph = 0; pulse_exp = 1'b1;
    end else begin
      ph++; pulse_exp = 1'b0;
    end
    @(negedge clk);
    chk("R12", "sec_pulse", int'(sec_pulse), int'(pulse_exp));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check_all(string tag);
    for (int f = 0; f < 7; f++) begin
      rd_sel = 3'(f);
      #0.1;
      chk(tag, $sformatf("field%0d", f), int'(rd_data), int'(exp_field(f)));
    end
  endtask

  task automatic wr(int sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_all(int yr, int mo, int dt, int dw, logic [7:0] hb, int mn, int sc);
    wr(5, to_bcd(yr)); wr(4, to_bcd(mo)); wr(3, to_bcd(dt)); wr(6, 8'(dw));
    wr(2, hb); wr(1, to_bcd(mn)); wr(0, to_bcd(sc));
  endtask

  task automatic rollover(string tag, int yr, int mo, int dt, int dw,
                          logic [7:0] hb, int mn, int sc);
    set_all(yr, mo, dt, dw, hb, mn, sc);
    check_all("R9");
    run(CYC);
    check_all(tag);
  endtask

  function automatic logic [7:0] rand_hour();
    int h;
    if ($urandom % 2 == 1) begin
      h = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
      return 8'h80 | to_bcd(h);
    end
    h = ($urandom % 3 == 0) ? 11 : 1 + int'($urandom % 12);
    return (($urandom % 2 == 1) ? 8'h20 : 8'h00) | to_bcd(h);
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_all("R1");
    rd_sel = 3'd7; #0.1;
    chk("R9", "unused select", int'(rd_data), 0);

    // R11 plain counting from reset
    run(CYC * 3);
    check_all("R11");

    // R2 minute and hour carry
    rollover("R2", 5, 6, 10, 2, 8'h90, 59, 59);
    // R3 24-hour wrap into the next date
    rollover("R3", 12, 3, 14, 1, 8'hA3, 59, 59);
    // R7 year end, R8 weekday wrap
    rollover("R7", 99, 12, 31, 6, 8'hA3, 59, 59);
    rollover("R8", 40, 7, 4, 6, 8'hA3, 59, 59);
    // R5 month lengths
    rollover("R5", 30, 4, 30, 0, 8'hA3, 59, 59);
    rollover("R5", 30, 1, 31, 0, 8'hA3, 59, 59);
    rollover("R5", 30, 11, 30, 3, 8'hA3, 59, 59);
    rollover("R5", 23, 2, 28, 3, 8'hA3, 59, 59);
    // R6 leap years
    rollover("R6", 24, 2, 28, 4, 8'hA3, 59, 59);
    rollover("R6", 0, 2, 28, 4, 8'hA3, 59, 59);
    rollover("R6", 24, 2, 29, 5, 8'hA3, 59, 59);
    // R4 12-hour steps: 11 AM -> 12 PM, 12 PM -> 1 PM, 11 PM -> 12 AM
    rollover("R4", 10, 5, 9, 2, 8'h11, 59, 59);
    rollover("R4", 10, 5, 9, 2, 8'h32, 59, 59);
    rollover("R4", 10, 5, 9, 2, 8'h31, 59, 59);
    rollover("R4", 10, 5, 9, 2, 8'h12, 59, 59);

    // R10 write restarts phase: seconds hold for CYC-1 edges, then step
    wr(0, 8'h10);
    run(CYC - 1);
    rd_sel = 3'd0; #0.1;
    chk("R10", "sec before restart elapsed", int'(rd_data), 8'h10);
    run(1);
    rd_sel = 3'd0; #0.1;
    chk("R10", "sec after restart elapsed", int'(rd_data), 8'h11);
    // R10 write in the cycle of a due tick drops that tick
    while (ph != CYC - 1) step();
    wr(1, 8'h33);
    check_all("R10");
    run(CYC - 1);
    check_all("R10");
    run(1);
    check_all("R10");

    // random mix of loads and idle stretches
    for (int it = 0; it < 400; it++) begin
      int f;
      if ($urandom % 3 == 0) begin
        f = int'($urandom % 7);
        case (f)
          0: wr(0, to_bcd(($urandom % 3 == 0) ? 59 : int'($urandom % 60)));
          1: wr(1, to_bcd(($urandom % 3 == 0) ? 59 : int'($urandom % 60)));
          2: wr(2, rand_hour());
          3: wr(3, to_bcd(1 + int'($urandom % days_of(m_mon, m_year))));
          4: wr(4, to_bcd(1 + int'($urandom % 12)));
          5: wr(5, to_bcd(int'($urandom % 100)));
          default: wr(6, 8'($urandom % 7));
        endcase
        check_all("R9");
      end else begin
        run(1 + int'($urandom % 12));
        check_all("R11");
      end
    end

    summary();
    $finish;
  end
endmodule